// File: doc/BRIEF.md
# Cycle and Event Performance Monitor

A small performance-monitoring block with three 32-bit counters: one cycle counter and two event counters. Each event counter counts cycles where one line of an input event vector is high. An 8-bit code in the control word picks that line. One control/status word holds several fields:

- the global run bit
- self-clearing counter resets
- a long-period mode for the cycle counter
- three interrupt enables
- three sticky, write-one-to-clear overflow flags
- the two event-select codes

Software reaches the control word and the three counters through a plain synchronous port. The port has a 2-bit address, a write strobe and write data. Read data is combinational from the addressed register. A level interrupt is raised while any overflow flag is set and its matching enable is set.

Counting is controlled by a four-state machine whose state is the pair (run, long-period). The states are `ST_HALT_FAST`, `ST_HALT_SLOW`, `ST_RUN_FAST` and `ST_RUN_SLOW`. The state changes only on a write to the control word. That write moves the machine straight to the state named by written bits 0 and 3, so any state can reach any other in one write:

- halt-to-run: set bit 0
- run-to-halt: clear bit 0
- fast-to-slow: set bit 3
- slow-to-fast: clear bit 3

In `ST_RUN_SLOW` a 64-step prescaler paces the cycle counter. The prescaler is held at zero in every other state.

Top module: `perfmon_unit`

## Requirements
- R1: After reset, the control word reads 0x0FFFF000 (both select codes 0xFF, everything else 0), all three counters read 0 and `irq` is low.
- R2: Register addresses are: 0 for the control word, 1 for the cycle counter, 2 for event counter 0 and 3 for event counter 1. A write to a counter address loads the written value, and the counter reads it back.
- R3: While control bit 0 is clear, no counter changes except by a software write or a reset bit.
- R4: With bit 0 set and bit 3 clear, the cycle counter adds one on every clock edge.
- R5: With bits 0 and 3 set, the cycle counter adds one on the 64th edge after it enters that mode, and every 64 edges after that. Leaving the mode restarts the 64-edge count.
- R6: Bits 19:12 select the event for counter 0 and bits 27:20 select the event for counter 1. A code below 23 counts edges where `evt_in[code]` is high. Any code of 23 or more, including 0xFF, counts nothing.
- R7: Writing 1 to bit 1 zeroes both event counters, and writing 1 to bit 2 zeroes the cycle counter. A reset overrides counting on the same edge, and both bits read back as 0.
- R8: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter. Flags are sticky, and a later overflow never clears an earlier flag.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If an overflow and its clear land on the same edge, the flag ends up set.
- R10: `irq` is high exactly while some flag is set together with its enable: bit 4 for event counter 0, bit 5 for event counter 1, bit 6 for the cycle counter.
- R11: Bits 7, 11 and 31:28 of the control word always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| evt_in | input | 23 | Event lines, one per select code |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check these properties on every cycle:

- a halted unit leaves all counters frozen;
- an overflow flag is never lost except through a write-one clear;
- a wrap of the cycle counter or event counter 0 leaves its flag set;
- the reserved and self-clearing bits read zero;
- `irq` never rises without a flag;
- the long-period cycle counter never advances on two edges in a row.

Only the bench scenarios can show the exact counts against time. These include:

- the 63- and 64-edge boundary of the long-period mode;
- which event line each select code picks, and that codes of 23 or more count nothing;
- that an overflow wins over a simultaneous clear;
- how irq follows changes to the interrupt enables.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int SEL_W    = 8;
    localparam int N_CNT    = 3;   // cycle counter plus two event counters
    localparam int N_EVCNT  = N_CNT - 1;

    // control word field positions (decoded by software)
    localparam int B_RUN    = 0;
    localparam int B_EVRST  = 1;
    localparam int B_CYRST  = 2;
    localparam int B_SLOW   = 3;
    localparam int B_IEN    = 4;   // three bits: ev0, ev1, cyc
    localparam int B_FLAG   = 8;   // three bits: ev0, ev1, cyc
    localparam int B_SEL0   = 12;
    localparam int B_SEL1   = 20;

    localparam logic [DATA_W-1:0] WR_MASK = 32'h0FFF_F77F;
    localparam logic [SEL_W-1:0]  SEL_OFF = 8'hFF;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;

    // counter index k lives at address k+1; index 0 is the cycle counter
    typedef enum logic [1:0] {
        ST_HALT_FAST = 2'b00,
        ST_HALT_SLOW = 2'b01,
        ST_RUN_FAST  = 2'b10,
        ST_RUN_SLOW  = 2'b11
    } run_state_e;

    // position of a counter's flag/enable inside its 3-bit field
    function automatic int slot_of(input int k);
        return (k == 0) ? N_CNT - 1 : k - 1;
    endfunction

endpackage

// File: rtl/perfmon_fsm.sv
module perfmon_fsm
    import perfmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_run,
    input  logic cfg_slow,
    output logic run,
    output logic slow
);

    run_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            unique case ({cfg_run, cfg_slow})
                2'b00: st_d = ST_HALT_FAST;
                2'b01: st_d = ST_HALT_SLOW;
                2'b10: st_d = ST_RUN_FAST;
                2'b11: st_d = ST_RUN_SLOW;
                default: st_d = ST_HALT_FAST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT_FAST;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_HALT_FAST: begin run = 1'b0; slow = 1'b0; end
            ST_HALT_SLOW: begin run = 1'b0; slow = 1'b1; end
            ST_RUN_FAST:  begin run = 1'b1; slow = 1'b0; end
            ST_RUN_SLOW:  begin run = 1'b1; slow = 1'b1; end
            default:      begin run = 1'b0; slow = 1'b0; end
        endcase
    end

endmodule

// File: rtl/perfmon_prescaler.sv
module perfmon_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    input  logic clr,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (clr || !(run && slow)) cnt_q <= '0;
        else if (cnt_q == LAST)       cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (!slow || (cnt_q == LAST));

endmodule

// File: rtl/perfmon_evsel.sv
module perfmon_evsel #(
    parameter int NUM_EVT = 23,
    parameter int SEL_W   = 8
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_EVT-1:0] evt,
    output logic               hit
);

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel == SEL_W'(i)) hit = evt[i];
        end
    end

endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   value <= '0;
        else if (clr) value <= '0;
        else if (ld)  value <= ld_val;
        else if (inc) value <= value + 1'b1;
    end

    assign wrap = inc && !clr && !ld && (value == '1);

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
    import perfmon_pkg::*;
#(
    parameter int NUM_EVT      = 23,
    parameter int PRESCALE_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic              irq
);

    logic                      ctrl_wr;
    logic [DATA_W-1:0]         wmask;
    logic                      run_q, slow_q, cyc_tick;
    logic [N_CNT-1:0]          ien_q, flag_q, flag_d;
    logic [N_CNT-1:0]          wrap_slot, clr_req;
    logic [N_EVCNT-1:0][SEL_W-1:0] sel_q;
    logic [N_EVCNT-1:0]        ev_hit;
    logic [N_CNT-1:0][DATA_W-1:0] cnt_val;
    logic [DATA_W-1:0]         ctrl_rd;
    logic                      unused_wbits;

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign wmask   = bus_wdata & WR_MASK;
    assign unused_wbits = ^{wmask[31:28], wmask[11], wmask[7]};

    perfmon_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (ctrl_wr),
        .cfg_run  (wmask[B_RUN]),
        .cfg_slow (wmask[B_SLOW]),
        .run      (run_q),
        .slow     (slow_q)
    );

    perfmon_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .slow  (slow_q),
        .clr   (clr_req[0]),
        .tick  (cyc_tick)
    );

    // event selection, one multiplexer per event counter
    for (genvar e = 0; e < N_EVCNT; e++) begin : g_sel
        perfmon_evsel #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_evsel (
            .sel (sel_q[e]),
            .evt (evt_in),
            .hit (ev_hit[e])
        );
    end

    // counters: index 0 counts cycles, index k>0 counts event counter k-1
    for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
        localparam int SLOT = slot_of(k);
        localparam int RBIT = (k == 0) ? B_CYRST : B_EVRST;
        logic inc_k, wrap_k, ld_k;

        assign clr_req[k] = ctrl_wr && wmask[RBIT];
        assign ld_k       = bus_wr && (bus_addr == ADDR_W'(k + 1));
        if (k == 0) begin : g_cyc
            assign inc_k = cyc_tick;
        end else begin : g_evt
            assign inc_k = run_q && ev_hit[k-1];
        end

        perfmon_counter #(.W(DATA_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_req[k]),
            .ld     (ld_k),
            .ld_val (bus_wdata),
            .inc    (inc_k),
            .value  (cnt_val[k]),
            .wrap   (wrap_k)
        );
        assign wrap_slot[SLOT] = wrap_k;
    end

    // sticky flags: write-one clears, a new wrap wins over a clear
    always_comb begin
        flag_d = flag_q;
        if (ctrl_wr) flag_d = flag_d & ~wmask[B_FLAG +: N_CNT];
        flag_d = flag_d | wrap_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            flag_q <= '0;
            sel_q  <= {N_EVCNT{SEL_OFF}};
        end else begin
            flag_q <= flag_d;
            if (ctrl_wr) begin
                ien_q    <= wmask[B_IEN +: N_CNT];
                sel_q[0] <= wmask[B_SEL0 +: SEL_W];
                sel_q[1] <= wmask[B_SEL1 +: SEL_W];
            end
        end
    end

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[B_RUN]               = run_q;
        ctrl_rd[B_SLOW]              = slow_q;
        ctrl_rd[B_IEN +: N_CNT]      = ien_q;
        ctrl_rd[B_FLAG +: N_CNT]     = flag_q;
        ctrl_rd[B_SEL0 +: SEL_W]     = sel_q[0];
        ctrl_rd[B_SEL1 +: SEL_W]     = sel_q[1];
    end

    always_comb begin
        unique case (bus_addr)
            2'd0: bus_rdata = ctrl_rd;
            2'd1: bus_rdata = cnt_val[0];
            2'd2: bus_rdata = cnt_val[1];
            2'd3: bus_rdata = cnt_val[2];
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |(flag_q & ien_q);

endmodule

// File: rtl/perfmon_unit_chk.sv
module perfmon_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        irq,
    input logic [31:0] ctrl_rd,
    input logic [2:0][31:0] cnt_val
);

    logic [1:0] age;
    logic       p1, p2;
    logic [2:0] flags, clr_mask, keep;
    logic       run, slow, slow_nowr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assign p1        = (age >= 2'd1);
    assign p2        = (age >= 2'd2);
    assign flags     = ctrl_rd[10:8];
    assign run       = ctrl_rd[0];
    assign slow      = ctrl_rd[3];
    assign clr_mask  = (bus_wr && bus_addr == 2'd0) ? bus_wdata[10:8] : 3'b000;
    assign keep      = flags & ~clr_mask;
    assign slow_nowr = run && slow && !bus_wr;

    assert_halt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        p1 && $past(!run && !bus_wr) |-> cnt_val == $past(cnt_val));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        p1 |-> ((flags & $past(keep)) == $past(keep)));

    assert_cyc_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        p1 && !$past(bus_wr) && $past(cnt_val[0]) == 32'hFFFF_FFFF && cnt_val[0] == 32'h0
        |-> flags[2]);

    assert_ev0_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        p1 && !$past(bus_wr) && $past(cnt_val[1]) == 32'hFFFF_FFFF && cnt_val[1] == 32'h0
        |-> flags[0]);

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 2'd0 |-> (bus_rdata & 32'hF000_0886) == 32'h0);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flags != 3'b000);

    assert_slow_no_double_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        p2 && $past(slow_nowr, 1) && $past(slow_nowr, 2) && cnt_val[0] != $past(cnt_val[0])
        |-> $past(cnt_val[0], 1) == $past(cnt_val[0], 2));

endmodule

bind perfmon_unit perfmon_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ctrl_rd   (ctrl_rd),
    .cnt_val   (cnt_val)
);

// File: tb/perfmon_unit_test.sv
`timescale 1ns/1ps
module perfmon_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [22:0] evt = 23'h0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    perfmon_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt),
        .irq       (irq)
    );

    // monitor: compares queued expectations half a cycle after they are driven
    always @(negedge clk) begin
        while (q_kind.size() > 0) begin
            int          k;
            logic [31:0] e, act;
            string       t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            act = (k == 1) ? {31'h0, irq} : bus_rdata;
            n_chk++;
            if (act !== e) begin
                n_fail++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", t, act, e);
            end
        end
    end

    task automatic step(input logic w, input logic [1:0] a,
                        input logic [31:0] d, input logic [22:0] e);
        @(posedge clk); #1;
        bus_wr = w; bus_addr = a; bus_wdata = d; evt = e;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        step(1'b1, a, d, 23'h0);
    endtask

    task automatic idle(input int n, input logic [22:0] e);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'h0, e);
    endtask

    task automatic chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, a, 32'h0, 23'h0);
        q_kind.push_back(0); q_exp.push_back(exp); q_tag.push_back(tag);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        step(1'b0, 2'd0, 32'h0, 23'h0);
        q_kind.push_back(1); q_exp.push_back({31'h0, exp}); q_tag.push_back(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [22:0] pat;
        int e0, e1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(2'd0, 32'h0FFF_F000, "R1 ctrl");
        chk(2'd1, 32'h0, "R1 cyc");
        chk(2'd2, 32'h0, "R1 ev0");
        chk(2'd3, 32'h0, "R1 ev1");
        chk_irq(1'b0, "R1 irq");

        // R11 reserved bits, R7 reset bits read 0
        wr(2'd0, 32'hFFFF_F886);
        chk(2'd0, 32'h0FFF_F000, "R11 reserved and R7 self-clear");

        // R2 load and read back, R3 frozen while halted
        wr(2'd1, 32'h1234_5678);
        wr(2'd2, 32'hA5A5_A5A5);
        wr(2'd3, 32'h0000_0042);
        idle(5, 23'h7F_FFFF);
        chk(2'd1, 32'h1234_5678, "R2 R3 cyc");
        chk(2'd2, 32'hA5A5_A5A5, "R2 R3 ev0");
        chk(2'd3, 32'h0000_0042, "R2 R3 ev1");

        // R4 fast cycle counting; R6 code 0xFF counts nothing
        wr(2'd0, 32'h0FFF_F005);
        idle(10, 23'h7F_FFFF);
        wr(2'd0, 32'h0FFF_F000);
        chk(2'd1, 32'd11, "R4 cyc count");
        chk(2'd2, 32'hA5A5_A5A5, "R6 sel 0xFF ev0");
        chk(2'd3, 32'h0000_0042, "R6 sel 0xFF ev1");

        // R6 select codes 5 and 7 on a pseudo-random pattern, R7 event reset
        wr(2'd0, 32'h0070_5003);
        pat = 23'h5A5A5; e0 = 0; e1 = 0;
        for (int i = 0; i < 20; i++) begin
            pat = {pat[21:0], pat[22] ^ pat[17]};
            step(1'b0, 2'd0, 32'h0, pat);
            e0 += int'(pat[5]);
            e1 += int'(pat[7]);
        end
        wr(2'd0, 32'h0070_5000);
        chk(2'd2, 32'(e0), "R6 ev0 code 5");
        chk(2'd3, 32'(e1), "R6 ev1 code 7");

        // R6 code 23 counts nothing, code 22 counts
        wr(2'd0, 32'h0161_7003);
        idle(8, 23'h7F_FFFF);
        wr(2'd0, 32'h0161_7000);
        chk(2'd2, 32'h0, "R6 code 23 idle");
        chk(2'd3, 32'd8, "R6 code 22");

        // R5 long-period boundary: 63, 64 and 128 counting edges
        wr(2'd0, 32'h0FFF_F00D);
        idle(62, 23'h0);
        wr(2'd0, 32'h0FFF_F000);
        chk(2'd1, 32'd0, "R5 63 edges");
        wr(2'd0, 32'h0FFF_F00D);
        idle(63, 23'h0);
        wr(2'd0, 32'h0FFF_F000);
        chk(2'd1, 32'd1, "R5 64 edges");
        wr(2'd0, 32'h0FFF_F00D);
        idle(127, 23'h0);
        wr(2'd0, 32'h0FFF_F000);
        chk(2'd1, 32'd2, "R5 128 edges");

        // R8 wrap sets flags, R10 interrupt
        wr(2'd1, 32'hFFFF_FFFE);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0FF0_0071);
        step(1'b0, 2'd0, 32'h0, 23'h1);
        wr(2'd0, 32'h0FF0_0070);
        chk(2'd0, 32'h0FF0_0570, "R8 flags ev0 cyc");
        chk(2'd1, 32'h0, "R8 cyc wrapped");
        chk(2'd2, 32'h0, "R8 ev0 wrapped");
        chk_irq(1'b1, "R10 irq set");

        // R9 write-one-to-clear, R10 enable masking
        wr(2'd0, 32'h0FF0_0170);
        chk(2'd0, 32'h0FF0_0470, "R9 clear ev0 flag");
        chk_irq(1'b1, "R10 cyc flag enabled");
        wr(2'd0, 32'h0FF0_0010);
        chk(2'd0, 32'h0FF0_0410, "R9 zero write keeps flag");
        chk_irq(1'b0, "R10 enable off");
        wr(2'd0, 32'h0FF0_0440);
        chk(2'd0, 32'h0FF0_0040, "R9 clear cyc flag");
        chk_irq(1'b0, "R10 no flag");

        // R8 sticky across a later overflow
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0010_0001);
        step(1'b0, 2'd0, 32'h0, 23'h2);
        step(1'b0, 2'd0, 32'h0, 23'h1);
        wr(2'd0, 32'h0010_0000);
        chk(2'd0, 32'h0010_0300, "R8 sticky both flags");
        chk_irq(1'b0, "R10 flags without enable");

        // R9 overflow wins over same-edge clear
        wr(2'd0, 32'h0010_0300);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0010_0001);
        step(1'b1, 2'd0, 32'h0010_0101, 23'h1);
        wr(2'd0, 32'h0010_0000);
        chk(2'd0, 32'h0010_0100, "R9 set wins over clear");

        // R7 separate resets
        wr(2'd1, 32'h777);
        wr(2'd2, 32'h99);
        wr(2'd3, 32'h55);
        wr(2'd0, 32'h0FFF_F002);
        chk(2'd1, 32'h777, "R7 cyc kept on event reset");
        chk(2'd2, 32'h0, "R7 ev0 reset");
        chk(2'd3, 32'h0, "R7 ev1 reset");
        wr(2'd2, 32'h99);
        wr(2'd0, 32'h0FFF_F004);
        chk(2'd1, 32'h0, "R7 cyc reset");
        chk(2'd2, 32'h99, "R7 ev0 kept on cycle reset");

        idle(2, 23'h0);
        finished = 1'b1;
        finish_run();
    end

endmodule